// File: doc/BRIEF.md
# Decoder control and status unit

This unit is the software-facing register and control front end of a bitstream decoder engine. It holds a 32-bit picture-parameter register and a status register with an error flag and a start-code flag. It drives a level interrupt request to the host, and it accepts commands that flush the decoder's output buffers or soft-reset the whole engine. The decoder core talks to it through single-cycle strobes. `core_err` reports a bitstream error, `core_sc` reports a start code held in the core's shift register, and `bus_busy` is high while a bus transaction is in flight. The unit answers with `buf_flush` and `buf_clear` pulses.

Registers are reached through a simple synchronous write port and a combinational read port, selected by a 2-bit address:
- Address 0: picture parameters.
- Address 1: status.
- Address 2: control, where bit 0 enables the interrupt.
- Address 3: command, which is write-only and reads as zero.

A soft reset does not take effect at once. The unit raises a busy bit and waits until no bus transaction is in flight, so that none is cut off. It then zeroes every register and pulses `buf_clear`. The active-low hardware reset gives the same cleared state immediately.

Top module: `vdec_ctl`

## Requirements
- R1: The picture-parameter register (address 0) is packed from bit 31 down in this order: type [31:30], structure [29:28], frame-prediction/frame-DCT [27], intra table select [26], concealment vectors [25], reserved [24:19], MPEG-2 mode [18], reserved [17:16], forward horizontal size [15:12], forward vertical size [11:8], backward horizontal size [7:4], backward vertical size [3:0]. Reserved bits read as zero and ignore writes, so a read returns the last write ANDed with 0xFE04FFFF.
- R2: A `core_err` pulse sets the error flag, status bit 0, in the cycle after the pulse.
- R3: `core_sc` sets the start-code flag, status bit 1. When it coincides with `core_err`, both flags are set.
- R4: Writing 1 to a status flag bit clears that flag. Writing 0 leaves it unchanged.
- R5: `irq` is high exactly while the error flag is set and interrupt enable (control bit 0) is 1, and it stays high until one of them is cleared.
- R6: Writing command bit 0 produces a one-cycle `buf_flush` pulse in the next cycle. An error never produces `buf_flush`.
- R7: Writing command bit 1 starts a soft reset. While it is pending, status bit 2 reads 1 and all register writes are ignored. The reset completes on the first clock edge at which `bus_busy` is low.
- R8: A completed soft reset zeroes all registers and gives a one-cycle `buf_clear` pulse. Asserting `rst_n` low zeroes all registers and outputs at once. If flush and soft reset are written together, only the reset acts.
- R9: If an error pulse and a write-one-to-clear of the error flag arrive in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| core_err | input | 1 | Bitstream error detected |
| core_sc | input | 1 | Start code present in the shift register |
| bus_busy | input | 1 | Bus transaction in flight |
| irq | output | 1 | Level interrupt request |
| buf_flush | output | 1 | Flush pulse for the output buffers |
| buf_clear | output | 1 | Clear pulse for the buffers at soft-reset completion |

## Verification
The assertions assume that the core strobes and `bus_busy` are synchronous to `clk` and change only between edges. They also assume that `bus_busy` eventually falls once a soft reset is pending. The bench drives every input at the falling edge and keeps the busy window short and finite. It deliberately overlaps error pulses with start codes, with flag-clearing writes and with the pending reset window, so that each priority rule is reached.

// File: rtl/vdec_ctl.sv
module vdec_ctl #(
  parameter int          DW       = 32,
  parameter int          AW       = 2,
  parameter logic [31:0] PIC_MASK = 32'hFE04_FFFF
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic [AW-1:0] reg_addr,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  input  logic          core_err,
  input  logic          core_sc,
  input  logic          bus_busy,
  output logic          irq,
  output logic          buf_flush,
  output logic          buf_clear
);
  localparam logic [AW-1:0] A_PIC  = AW'(0);
  localparam logic [AW-1:0] A_STAT = AW'(1);
  localparam logic [AW-1:0] A_CTRL = AW'(2);
  localparam logic [AW-1:0] A_CMD  = AW'(3);

  logic [DW-1:0] pic_q;
  logic err_q, sc_q, ien_q, pend_q, flush_q, clear_q;

  wire wr_ok    = reg_wr & ~pend_q;
  wire wr_pic   = wr_ok & (reg_addr == A_PIC);
  wire wr_stat  = wr_ok & (reg_addr == A_STAT);
  wire wr_ctrl  = wr_ok & (reg_addr == A_CTRL);
  wire wr_cmd   = wr_ok & (reg_addr == A_CMD);
  wire do_clear = pend_q & ~bus_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pic_q   <= '0;
      err_q   <= 1'b0;
      sc_q    <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
      clear_q <= 1'b0;
    end else if (do_clear) begin
      pic_q   <= '0;
      err_q   <= 1'b0;
      sc_q    <= 1'b0;
      ien_q   <= 1'b0;
      pend_q  <= 1'b0;
      flush_q <= 1'b0;
      clear_q <= 1'b1;
    end else begin
      clear_q <= 1'b0;
      if (wr_pic)  pic_q <= reg_wdata & DW'(PIC_MASK);
      if (wr_ctrl) ien_q <= reg_wdata[0];
      err_q   <= core_err | (err_q & ~(wr_stat & reg_wdata[0]));
      sc_q    <= core_sc  | (sc_q  & ~(wr_stat & reg_wdata[1]));
      pend_q  <= pend_q | (wr_cmd & reg_wdata[1]);
      flush_q <= wr_cmd & reg_wdata[0] & ~reg_wdata[1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_PIC:   reg_rdata = pic_q;
      A_STAT:  reg_rdata[2:0] = {pend_q, sc_q, err_q};
      A_CTRL:  reg_rdata[0] = ien_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq       = err_q & ien_q;
  assign buf_flush = flush_q;
  assign buf_clear = clear_q;

  p_err_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (core_err && !do_clear) |=> reg_rdata_err_chk(err_q));
  p_both_flags_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (core_err && core_sc && !do_clear) |=> (err_q && sc_q));
  p_irq_follows_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (core_err && ien_q && !do_clear && !wr_ctrl) |=> irq);
  p_flush_cmd_r6: assert property (@(posedge clk) disable iff (!rst_n)
    buf_flush |-> ($past(reg_wr) && $past(reg_addr) == A_CMD && $past(reg_wdata[0])));
  p_reset_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && bus_busy) |=> (pend_q && !buf_clear));
  p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_clear |-> (pic_q == '0 && !err_q && !sc_q && !ien_q && !pend_q && !buf_flush));
  p_set_wins_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (core_err && wr_stat && reg_wdata[0] && !do_clear) |=> err_q);

  function automatic logic reg_rdata_err_chk(input logic f);
    return f;
  endfunction
endmodule

// File: tb/vdec_ctl_bench.sv
module vdec_ctl_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic core_err = 1'b0, core_sc = 1'b0, bus_busy = 1'b0;
  logic irq, buf_flush, buf_clear;

  always #4 clk = ~clk;

  vdec_ctl u_vdec_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .core_err(core_err),
    .core_sc(core_sc), .bus_busy(bus_busy), .irq(irq),
    .buf_flush(buf_flush), .buf_clear(buf_clear)
  );

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  string tag = "R8";

  // behavioural reference state
  logic [31:0] m_pic;
  bit m_err, m_sc, m_en, m_pend, m_flush, m_clear;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pic = 0; m_err = 0; m_sc = 0; m_en = 0; m_pend = 0; m_flush = 0; m_clear = 0;
    end else begin
      bit accept;
      accept = reg_wr && !m_pend;
      m_flush = 0;
      m_clear = 0;
      if (m_pend && !bus_busy) begin
        m_pic = 0; m_err = 0; m_sc = 0; m_en = 0; m_pend = 0; m_clear = 1;
      end else begin
        if (accept && reg_addr == 1) begin
          if (reg_wdata[0]) m_err = 0;
          if (reg_wdata[1]) m_sc = 0;
        end
        if (core_err) m_err = 1;
        if (core_sc) m_sc = 1;
        if (accept && reg_addr == 0) m_pic = reg_wdata & 32'hFE04_FFFF;
        if (accept && reg_addr == 2) m_en = reg_wdata[0];
        if (accept && reg_addr == 3) begin
          if (reg_wdata[1]) m_pend = 1;
          else if (reg_wdata[0]) m_flush = 1;
        end
      end
    end
  end

  function automatic logic [31:0] model_read(input logic [1:0] a);
    case (a)
      2'd0: return m_pic;
      2'd1: return {29'd0, m_pend, m_sc, m_err};
      2'd2: return {31'd0, m_en};
      default: return 32'd0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rdata", reg_rdata, model_read(reg_addr));
    check("irq", {31'd0, irq}, {31'd0, m_err && m_en});
    check("buf_flush", {31'd0, buf_flush}, {31'd0, m_flush});
    check("buf_clear", {31'd0, buf_clear}, {31'd0, m_clear});
  endtask

  task automatic step(input logic wr, input logic [1:0] a, input logic [31:0] d,
                      input logic e, input logic s, input logic b);
    @(negedge clk);
    compare_all();
    reg_wr = wr; reg_addr = a; reg_wdata = d; core_err = e; core_sc = s; bus_busy = b;
  endtask

  task automatic idle(input logic [1:0] a, input int n);
    for (int i = 0; i < n; i++) step(0, a, 0, 0, 0, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R8: hardware reset state
    repeat (2) @(negedge clk);
    check("reset irq", {31'd0, irq}, 0);
    check("reset status", reg_rdata, 0);
    rst_n = 1'b1;
    idle(1, 2);
    // R1: picture register masking
    tag = "R1";
    step(1, 0, 32'hFFFF_FFFF, 0, 0, 0);
    idle(0, 1);
    @(negedge clk); check("R1 all ones", reg_rdata, 32'hFE04_FFFF);
    step(1, 0, 32'h1234_5678, 0, 0, 0);
    idle(0, 2);
    // R2 and R5: error sets flag, irq level
    tag = "R5";
    step(1, 2, 1, 0, 0, 0);
    tag = "R2";
    step(0, 1, 0, 1, 0, 0);
    idle(1, 4);
    // R3: start code together with error
    tag = "R3";
    step(1, 1, 3, 0, 0, 0);
    step(0, 1, 0, 1, 1, 0);
    idle(1, 2);
    step(0, 1, 0, 0, 1, 0);
    idle(1, 2);
    // R4: write 0 keeps, write 1 clears
    tag = "R4";
    step(1, 1, 0, 0, 0, 0);
    idle(1, 2);
    step(1, 1, 1, 0, 0, 0);
    idle(1, 2);
    step(1, 1, 2, 0, 0, 0);
    idle(1, 2);
    // R9: set beats clear
    tag = "R9";
    step(0, 1, 0, 1, 0, 0);
    step(1, 1, 1, 1, 0, 0);
    idle(1, 3);
    // R5: irq drops when enable cleared
    tag = "R5";
    step(1, 2, 0, 0, 0, 0);
    idle(1, 2);
    // R6: flush only on command
    tag = "R6";
    step(0, 1, 0, 1, 0, 0);
    idle(1, 2);
    step(1, 3, 1, 0, 0, 0);
    idle(1, 3);
    // R7: deferred soft reset, ignored writes, busy bit
    tag = "R7";
    step(1, 2, 1, 0, 0, 0);
    step(1, 0, 32'hA5A5_5A5A, 0, 1, 1);
    step(1, 3, 2, 0, 0, 1);
    step(1, 0, 32'hFFFF_FFFF, 1, 0, 1);
    step(1, 3, 1, 0, 0, 1);
    step(1, 2, 0, 0, 0, 1);
    step(0, 1, 0, 0, 0, 1);
    tag = "R8";
    idle(1, 1);
    idle(0, 3);
    // R8: flush and reset together, only reset acts
    step(1, 0, 32'h0F0F_0F0F, 0, 0, 0);
    step(1, 3, 3, 0, 0, 0);
    idle(0, 3);
    // R8: hardware reset mid-run
    step(1, 2, 1, 1, 1, 0);
    idle(1, 2);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R8 hw reset status", reg_rdata, 0);
    check("R8 hw reset irq", {31'd0, irq}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(0, 3);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule